// File: doc/BRIEF.md
# NAND Status and Identification Responder

This block supplies the data words a host reads back from a NAND flash device model after it has issued a read-status command or a read-identification command. A separate command sequencer decodes the bus and sends one-cycle pulses here. One pulse starts a status session, one starts an identification session, one reports a device reset command, and one reports any other command. The block keeps the status byte, which tracks the write-protect pin and the ready flag. Each host read strobe returns one word from the active session.

The control is a three-state machine. In IDLE no response is queued, and every read returns zero. In STATUS each read returns the live status byte and nothing advances. In IDENT four bytes are returned in order: manufacturer code, device code, a filler byte, and a geometry byte.

The transitions are as follows:
- The status pulse moves any state to STATUS.
- The identification pulse moves any state to IDENT and rewinds the byte index.
- The reset pulse and the other-command pulse move any state to IDLE.
- The fourth identification read moves IDENT to IDLE.

The data bus is 16 bits wide. Every response byte sits in the low half, with zeros above it, so an 8-bit host simply ignores the upper half.

Top module: `nand_sid_responder`

## Requirements
- R1: The status byte has bit 0 (error) at 0, bits 1 to 5 at 0, bit 6 as ready and bit 7 as not-write-protected. With the pin high and ready set, a status read therefore returns 0x00C0.
- R2: Status bit 7 equals the value `wp_n` had on the previous clock edge: 1 when the pin is high (writes allowed) and 0 when it is low.
- R3: A reset-command pulse sets the ready bit, leaves bit 7 under pin control, clears the other status bits and returns the machine to IDLE, so the next read returns 0.
- R4: In STATUS every read returns the current status byte without advancing. This continues until any command pulse arrives.
- R5: After an identification pulse, successive reads return the manufacturer code, then the device code, then the filler byte (parameter, default 0xA5).
- R6: The fourth identification byte is 0x55 for a large-page device on a 16-bit bus, 0x15 for a large-page device on an 8-bit bus, and 0xC0 for a small-page device.
- R7: A read strobe while `ce_n` is high returns 0 and does not advance the identification index.
- R8: A read while no response is queued returns 0. This covers reads after the fourth identification byte and reads after an other-command pulse.
- R9: Bits 15 to 8 of the read data are always 0.
- R10: When several pulses arrive in the same cycle, the priority is reset, then status, then identification, then other command. In that cycle the read strobe is ignored and the read data holds.
- R11: The read data changes on the clock edge that samples the strobe and holds its value in cycles with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_cmd | input | 1 | Pulse: device reset command latched |
| status_start | input | 1 | Pulse: read-status command latched |
| id_start | input | 1 | Pulse: read-identification command and its address latched |
| other_cmd | input | 1 | Pulse: any other command latched |
| wp_n | input | 1 | Write-protect pin; low means protected |
| ce_n | input | 1 | Chip enable; low means selected |
| rd_strobe | input | 1 | One-cycle host read request |
| cfg_manf_id | input | 8 | Manufacturer code |
| cfg_chip_id | input | 8 | Device code |
| cfg_large_page | input | 1 | 1 selects a large-page geometry byte |
| cfg_wide_bus | input | 1 | 1 marks a 16-bit device bus |
| rd_data | output | 16 | Read data word |

## Verification
The assertions assume that the command inputs are single-cycle pulses. They also assume that the configuration inputs stay constant while an identification session is in progress. The stimulus changes `cfg_*` only while the machine is in IDLE, and it applies each pulse for exactly one clock. The simultaneous-pulse cases are driven on purpose, to exercise the priority rule. Write-protect changes are made between reads, which checks the one-cycle lag of bit 7.

// File: rtl/nand_sid_pkg.sv
package nand_sid_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STATUS = 2'd1,
        ST_IDENT  = 2'd2
    } sid_state_e;

    localparam int STAT_READY_BIT = 6;
    localparam int STAT_WP_BIT    = 7;

    localparam logic [7:0] GEO_LARGE_WIDE   = 8'h55;
    localparam logic [7:0] GEO_LARGE_NARROW = 8'h15;
    localparam logic [7:0] GEO_SMALL        = 8'hC0;

    localparam int ID_LEN = 4;
endpackage

// File: rtl/nand_sid_status.sv
module nand_sid_status
    import nand_sid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reset_cmd,
    input  logic       wp_n,
    output logic [7:0] status_o
);
    logic wp_q;
    logic ready_q;

    // Pin sampler: bit 7 lags the pin by one edge.
    always_ff @(posedge clk) begin
        wp_q <= wp_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b1;
        end else if (reset_cmd) begin
            ready_q <= 1'b1;
        end
    end

    always_comb begin
        status_o                 = '0;
        status_o[STAT_READY_BIT] = ready_q;
        status_o[STAT_WP_BIT]    = wp_q;
    end

    assert_wp_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status_o[STAT_WP_BIT] == $past(wp_n));
endmodule

// File: rtl/nand_sid_idrom.sv
module nand_sid_idrom
    import nand_sid_pkg::*;
#(
    parameter logic [7:0] FILLER_BYTE = 8'hA5,
    parameter int         IDX_W       = 2
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       manf_id,
    input  logic [7:0]       chip_id,
    input  logic             large_page,
    input  logic             wide_bus,
    output logic [7:0]       byte_o
);
    logic [7:0] geo_byte;

    always_comb begin
        if (!large_page)   geo_byte = GEO_SMALL;
        else if (wide_bus) geo_byte = GEO_LARGE_WIDE;
        else               geo_byte = GEO_LARGE_NARROW;
    end

    always_comb begin
        unique case (idx)
            IDX_W'(0): byte_o = manf_id;
            IDX_W'(1): byte_o = chip_id;
            IDX_W'(2): byte_o = FILLER_BYTE;
            default:   byte_o = geo_byte;
        endcase
    end
endmodule

// File: rtl/nand_sid_responder.sv
module nand_sid_responder
    import nand_sid_pkg::*;
#(
    parameter int         DATA_W      = 16,
    parameter logic [7:0] FILLER_BYTE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_cmd,
    input  logic              status_start,
    input  logic              id_start,
    input  logic              other_cmd,
    input  logic              wp_n,
    input  logic              ce_n,
    input  logic              rd_strobe,
    input  logic [7:0]        cfg_manf_id,
    input  logic [7:0]        cfg_chip_id,
    input  logic              cfg_large_page,
    input  logic              cfg_wide_bus,
    output logic [DATA_W-1:0] rd_data
);
    localparam int               IDX_W    = $clog2(ID_LEN);
    localparam int               PAD_W    = DATA_W - 8;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_LEN - 1);

    sid_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [7:0]       status_w;
    logic [7:0]       id_byte;
    logic             cmd_any;
    logic             rd_go;

    assign cmd_any = reset_cmd | status_start | id_start | other_cmd;
    assign rd_go   = rd_strobe & ~ce_n & ~cmd_any;

    nand_sid_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_cmd (reset_cmd),
        .wp_n      (wp_n),
        .status_o  (status_w)
    );

    nand_sid_idrom #(
        .FILLER_BYTE (FILLER_BYTE),
        .IDX_W       (IDX_W)
    ) u_idrom (
        .idx        (idx_q),
        .manf_id    (cfg_manf_id),
        .chip_id    (cfg_chip_id),
        .large_page (cfg_large_page),
        .wide_bus   (cfg_wide_bus),
        .byte_o     (id_byte)
    );

    // Next state and identification index.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (reset_cmd) begin
            state_d = ST_IDLE;
        end else if (status_start) begin
            state_d = ST_STATUS;
        end else if (id_start) begin
            state_d = ST_IDENT;
            idx_d   = '0;
        end else if (other_cmd) begin
            state_d = ST_IDLE;
        end else if (rd_go) begin
            unique case (state_q)
                ST_IDENT: begin
                    if (idx_q == IDX_LAST) state_d = ST_IDLE;
                    else                   idx_d   = idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (!cmd_any && rd_strobe) begin
            if (ce_n) begin
                rd_data <= '0;
            end else begin
                unique case (state_q)
                    ST_STATUS: rd_data <= {{PAD_W{1'b0}}, status_w};
                    ST_IDENT:  rd_data <= {{PAD_W{1'b0}}, id_byte};
                    default:   rd_data <= '0;
                endcase
            end
        end
    end

    assert_ce_high_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && ce_n && !cmd_any) |=> (rd_data == '0 && idx_q == $past(idx_q)));

    assert_status_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STATUS && !cmd_any) |=> state_q == ST_STATUS);

    assert_reset_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> (state_q == ST_IDLE && status_w[STAT_READY_BIT]));

    assert_prio_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_cmd && (status_start || id_start)) |=> state_q == ST_IDLE);

    assert_prio_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_cmd && status_start && id_start) |=> state_q == ST_STATUS);

    assert_id_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDENT && rd_go && idx_q != IDX_LAST)
            |=> (state_q == ST_IDENT && idx_q == $past(idx_q) + 1'b1));

    assert_id_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDENT && rd_go && idx_q == IDX_LAST) |=> state_q == ST_IDLE);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe) |=> $stable(rd_data));
endmodule

// File: tb/tb_nand_sid_responder.sv
module tb_nand_sid_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_cmd = 1'b0, status_start = 1'b0, id_start = 1'b0, other_cmd = 1'b0;
    logic        wp_n = 1'b1, ce_n = 1'b0, rd_strobe = 1'b0;
    logic [7:0]  cfg_manf_id = 8'hEC, cfg_chip_id = 8'hDA;
    logic        cfg_large_page = 1'b1, cfg_wide_bus = 1'b1;
    logic [15:0] rd_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nand_sid_responder dut (
        .clk(clk), .rst_n(rst_n), .reset_cmd(reset_cmd), .status_start(status_start),
        .id_start(id_start), .other_cmd(other_cmd), .wp_n(wp_n), .ce_n(ce_n),
        .rd_strobe(rd_strobe), .cfg_manf_id(cfg_manf_id), .cfg_chip_id(cfg_chip_id),
        .cfg_large_page(cfg_large_page), .cfg_wide_bus(cfg_wide_bus), .rd_data(rd_data)
    );

    // Behavioural reference: mode 0 none, 1 status, 2 ident.
    int          m_mode = 0;
    int          m_idx = 0;
    bit          m_wp = 1'b1;
    logic [15:0] m_data = 16'h0;

    function automatic logic [7:0] exp_id(int k);
        case (k)
            0: return cfg_manf_id;
            1: return cfg_chip_id;
            2: return 8'hA5;
            default: return !cfg_large_page ? 8'hC0 : (cfg_wide_bus ? 8'h55 : 8'h15);
        endcase
    endfunction

    always @(posedge clk) begin
        bit cmd;
        cmd = reset_cmd | status_start | id_start | other_cmd;
        if (!rst_n) begin
            m_mode = 0; m_idx = 0; m_data = 16'h0;
        end else if (cmd) begin
            if (reset_cmd)         m_mode = 0;
            else if (status_start) m_mode = 1;
            else if (id_start) begin m_mode = 2; m_idx = 0; end
            else                   m_mode = 0;
        end else if (rd_strobe) begin
            if (ce_n) m_data = 16'h0;
            else if (m_mode == 1) m_data = {8'h00, m_wp, 1'b1, 6'b0};
            else if (m_mode == 2) begin
                m_data = {8'h00, exp_id(m_idx)};
                if (m_idx == 3) m_mode = 0; else m_idx++;
            end else m_data = 16'h0;
        end
        m_wp = wp_n;
    end

    task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model; R9 upper byte is covered here.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rd_data, m_data, "R11 cycle compare");
            check({8'h00, rd_data[15:8]}, 16'h0, "R9 upper byte");
        end
    end

    task automatic pulse(int which);
        @(negedge clk);
        case (which)
            0: reset_cmd = 1'b1;
            1: status_start = 1'b1;
            2: id_start = 1'b1;
            default: other_cmd = 1'b1;
        endcase
        @(negedge clk);
        reset_cmd = 1'b0; status_start = 1'b0; id_start = 1'b0; other_cmd = 1'b0;
    endtask

    task automatic rd(output logic [15:0] v);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        v = rd_data;
    endtask

    task automatic id_session(logic lp, logic wb, logic [7:0] g, string tag);
        logic [15:0] v;
        cfg_large_page = lp; cfg_wide_bus = wb;
        pulse(2);
        rd(v); check(v, {8'h00, cfg_manf_id}, "R5 manufacturer");
        rd(v); check(v, {8'h00, cfg_chip_id}, "R5 device");
        rd(v); check(v, 16'h00A5, "R5 filler");
        rd(v); check(v, {8'h00, g}, tag);
        rd(v); check(v, 16'h0, "R8 after ident");
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                done = 1;
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data, 16'h0, "R3 reset state");
        rd(v); check(v, 16'h0, "R8 idle read");

        pulse(1);
        rd(v); check(v, 16'h00C0, "R1 status layout");
        rd(v); check(v, 16'h00C0, "R4 repeat");
        wp_n = 1'b0;
        @(negedge clk);
        rd(v); check(v, 16'h0040, "R2 protected");
        wp_n = 1'b1;
        rd(v); check(v, 16'h00C0, "R2 unprotected");
        pulse(3);
        rd(v); check(v, 16'h0, "R4 ends on command");

        id_session(1'b1, 1'b1, 8'h55, "R6 large wide");
        id_session(1'b1, 1'b0, 8'h15, "R6 large narrow");
        id_session(1'b0, 1'b1, 8'hC0, "R6 small");

        cfg_manf_id = 8'h2C; cfg_chip_id = 8'hF1; cfg_large_page = 1'b1; cfg_wide_bus = 1'b0;
        pulse(2);
        rd(v); check(v, 16'h002C, "R5 manufacturer");
        ce_n = 1'b1;
        rd(v); check(v, 16'h0, "R7 ce high");
        ce_n = 1'b0;
        rd(v); check(v, 16'h00F1, "R7 no advance");
        pulse(0);
        rd(v); check(v, 16'h0, "R3 reset empties");

        // Simultaneous pulses.
        @(negedge clk); status_start = 1'b1; id_start = 1'b1; rd_strobe = 1'b1;
        @(negedge clk); status_start = 1'b0; id_start = 1'b0; rd_strobe = 1'b0;
        check(rd_data, 16'h0, "R10 strobe ignored");
        rd(v); check(v, 16'h00C0, "R10 status wins");
        @(negedge clk); reset_cmd = 1'b1; status_start = 1'b1;
        @(negedge clk); reset_cmd = 1'b0; status_start = 1'b0;
        rd(v); check(v, 16'h0, "R10 reset wins");
        @(negedge clk); id_start = 1'b1; other_cmd = 1'b1;
        @(negedge clk); id_start = 1'b0; other_cmd = 1'b0;
        rd(v); check(v, 16'h002C, "R10 ident over other");
        repeat (3) @(negedge clk);
        check(rd_data, 16'h002C, "R11 hold");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule